// File: doc/BRIEF.md
# Double-Edge Read Capture with Half-Rate Clock Crossing

This block takes one or more single-bit data lanes that toggle on both edges of a read capture clock and turns them into a wide, single-edge word in a slower system clock domain. For each lane, one flop samples on the rising edge of the capture clock and another samples on the falling edge. A realignment stage then loads both samples together on the next rising edge, so that each lane yields one two-bit pair per capture cycle.

Pairs pass through a small dual-clock FIFO whose write and read pointers cross clocks in Gray code. The read side runs at half the capture rate. On each read it pops two pairs, so each lane gives a four-bit word per system cycle. A bypass input keeps captured pairs out of the FIFO. The realigned pairs are always visible on a capture-domain port, so in bypass they can be taken from there directly.

Top module: `ddr_rd_capture`

## Requirements
- R1: For lane l, `cap_pair[2l]` holds the bit present at a rising capture edge and `cap_pair[2l+1]` holds the bit present at the falling edge that follows. The two bits appear together, updated on the next rising edge, and `cap_vld` is high for exactly one capture cycle per pair.
- R2: A pair is produced only when `cap_en` was high at the rising edge that sampled its first bit.
- R3: For lane l, the output word `dout[4l+3:4l]` carries the older pair in bits 4l+1:4l and the newer pair in bits 4l+3:4l+2. Over time the lane bits therefore read in arrival order from bit 0 to bit 3.
- R4: A read pops two pairs in one read-clock cycle when `rd_en` is high and at least two pairs are stored. `dout_vld` is high for one cycle after each such pop, and no word is produced while `rd_en` is low. Words come out in the order their data arrived.
- R5: A single stored pair with no partner stays in the FIFO and is not output until a second pair arrives.
- R6: The FIFO holds at most DEPTH pairs (8 by default). While it is full, `fifo_full` is high and further pairs are dropped.
- R7: `fifo_empty` is high when the read side sees no stored pair. No word is produced while it is high.
- R8: While `fifo_bypass` is high, pairs are still presented on `cap_pair`/`cap_vld` but are not written into the FIFO.
- R9: Asserting `rst_n` low clears the FIFO at once: `dout_vld` low, `fifo_empty` high, `fifo_full` low. Data that was stored before the reset is discarded, and data captured after the reset comes out correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cap_clk | input | 1 | Read capture clock, both edges used |
| rd_clk | input | 1 | Half-rate system read clock |
| rst_n | input | 1 | Asynchronous active-low reset, released per domain |
| dq | input | LANES | Double-rate data lanes |
| cap_en | input | 1 | Capture window, sampled on rising capture edges |
| fifo_bypass | input | 1 | Keep captured pairs out of the FIFO |
| rd_en | input | 1 | Read request in the system domain |
| cap_pair | output | 2*LANES | Realigned pair per lane, capture domain |
| cap_vld | output | 1 | Pair valid, capture domain |
| fifo_full | output | 1 | FIFO full, capture domain |
| dout | output | 4*LANES | Four-bit word per lane, system domain |
| dout_vld | output | 1 | Word valid |
| fifo_empty | output | 1 | FIFO empty, system domain |

## Verification
A swapped edge register or a broken realignment stage shows up as swapped or shifted bit positions in the first word after data starts. A wrong pointer or Gray conversion shows up as repeated, missing or reordered words within a few read cycles of the point where the FIFO wraps or fills. A miscount in the pairing logic either releases a half-filled word or never releases the second word of an odd burst, and this is visible as soon as the burst goes idle. A bad full or bypass condition lets extra pairs into the FIFO, so the words read out after a fill or a bypass burst are wrong.

// File: rtl/ddrcap_pkg.sv
package ddrcap_pkg;
  // default geometry of the capture path
  localparam int unsigned DEF_LANES = 2;
  localparam int unsigned DEF_DEPTH = 8;
  // per-lane bit counts at each stage
  localparam int unsigned PAIR_BITS = 2;
  localparam int unsigned WORD_BITS = 2 * PAIR_BITS;
endpackage

// File: rtl/ddrcap_rst_sync.sv
module ddrcap_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= '0;
    else         stage_q <= stage_d;
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/ddrcap_sync_vec.sv
module ddrcap_sync_vec #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= d;
      hold_q <= meta_q;
    end
  end

  assign q = hold_q;
endmodule

// File: rtl/ddrcap_front.sv
module ddrcap_front #(
  parameter int unsigned LANES = ddrcap_pkg::DEF_LANES
) (
  input  logic                 cap_clk,
  input  logic                 rst_n,
  input  logic [LANES-1:0]     dq,
  input  logic                 cap_en,
  output logic [2*LANES-1:0]   pair,
  output logic                 pair_vld
);
  localparam int unsigned PW = ddrcap_pkg::PAIR_BITS * LANES;

  logic          en_q;
  logic          vld_q;
  logic [PW-1:0] pair_q;

  // window flag travels with the rising-edge sample
  always_ff @(posedge cap_clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      en_q  <= cap_en;
      vld_q <= en_q;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic rise_q;
    logic fall_q;

    // stage A: rising-edge sample, loaded only inside the window
    always_ff @(posedge cap_clk or negedge rst_n) begin
      if (!rst_n)      rise_q <= 1'b0;
      else if (cap_en) rise_q <= dq[l];
    end

    // stage B: falling-edge sample
    always_ff @(negedge cap_clk or negedge rst_n) begin
      if (!rst_n) fall_q <= 1'b0;
      else        fall_q <= dq[l];
    end

    // stage C: both samples move together on the next rising edge
    always_ff @(posedge cap_clk or negedge rst_n) begin
      if (!rst_n)    pair_q[2*l +: 2] <= 2'b00;
      else if (en_q) pair_q[2*l +: 2] <= {fall_q, rise_q};
    end
  end

  assign pair     = pair_q;
  assign pair_vld = vld_q;

  // R1
  pair_hold_chk: assert property (@(posedge cap_clk) disable iff (!rst_n)
    !pair_vld |-> $stable(pair));
  // R2
  pair_window_chk: assert property (@(posedge cap_clk) disable iff (!rst_n)
    pair_vld |-> $past(cap_en, 2));
endmodule

// File: rtl/ddrcap_cdc_fifo.sv
module ddrcap_cdc_fifo #(
  parameter int unsigned W     = 4,
  parameter int unsigned DEPTH = ddrcap_pkg::DEF_DEPTH
) (
  input  logic           wclk,
  input  logic           wrst_n,
  input  logic           wr_en,
  input  logic [W-1:0]   wdata,
  output logic           full,
  input  logic           rclk,
  input  logic           rrst_n,
  input  logic           rd_en,
  output logic [2*W-1:0] rdata,
  output logic           rvld,
  output logic           empty
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;   // entry pointer width
  localparam int unsigned QW = AW;       // pair pointer width (entry ptr >> 1)

  function automatic logic [PW-1:0] gray2bin_p(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = int'(PW) - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [QW-1:0] gray2bin_q(input logic [QW-1:0] g);
    logic [QW-1:0] b;
    b[QW-1] = g[QW-1];
    for (int i = int'(QW) - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [W-1:0]   mem [DEPTH];

  // write domain
  logic [PW-1:0]  wbin_q, wbin_d, wgray_q, wgray_d;
  logic [PW-1:0]  rent_w, used_w;
  logic [QW-1:0]  rgray_w, rpair_w;
  logic           wfire;

  // read domain
  logic [QW-1:0]  rp_q, rp_d, rgray_q, rgray_d;
  logic [PW-1:0]  wgray_r, wbin_r, rent_r, avail_r;
  logic [AW-1:0]  raddr0, raddr1;
  logic           rfire;
  logic [2*W-1:0] rdata_q;
  logic           rvld_q;

  ddrcap_sync_vec #(.W(QW)) u_rptr_sync (
    .clk(wclk), .rst_n(wrst_n), .d(rgray_q), .q(rgray_w)
  );
  ddrcap_sync_vec #(.W(PW)) u_wptr_sync (
    .clk(rclk), .rst_n(rrst_n), .d(wgray_q), .q(wgray_r)
  );

  // write side next state
  always_comb begin
    rpair_w = gray2bin_q(rgray_w);
    rent_w  = {rpair_w, 1'b0};
    used_w  = wbin_q - rent_w;
    full    = (used_w == PW'(DEPTH));
    wfire   = wr_en && !full;
    wbin_d  = wbin_q + PW'(wfire);
    wgray_d = wbin_d ^ (wbin_d >> 1);
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
    end
  end

  always_ff @(posedge wclk) begin
    if (wfire) mem[wbin_q[AW-1:0]] <= wdata;
  end

  // read side next state
  always_comb begin
    wbin_r  = gray2bin_p(wgray_r);
    rent_r  = {rp_q, 1'b0};
    avail_r = wbin_r - rent_r;
    empty   = (avail_r == '0);
    rfire   = rd_en && (avail_r >= PW'(2));
    rp_d    = rp_q + QW'(rfire);
    rgray_d = rp_d ^ (rp_d >> 1);
    raddr0  = rent_r[AW-1:0];
    raddr1  = {rent_r[AW-1:1], 1'b1};
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rp_q    <= '0;
      rgray_q <= '0;
      rvld_q  <= 1'b0;
    end else begin
      rp_q    <= rp_d;
      rgray_q <= rgray_d;
      rvld_q  <= rfire;
    end
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n)    rdata_q <= '0;
    else if (rfire) rdata_q <= {mem[raddr1], mem[raddr0]};
  end

  assign rdata = rdata_q;
  assign rvld  = rvld_q;

  // R6
  no_overfill_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    used_w <= PW'(DEPTH));
  // R4
  wgray_step_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    $countones(wgray_q ^ $past(wgray_q)) <= 1);
  // R4
  rgray_step_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    $countones(rgray_q ^ $past(rgray_q)) <= 1);
  // R4
  idle_read_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    !rd_en |=> !rvld);
  // R7
  empty_read_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    empty |=> !rvld);
  // R5
  lone_pair_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    (avail_r == PW'(1)) |=> !rvld);
endmodule

// File: rtl/ddr_rd_capture.sv
module ddr_rd_capture #(
  parameter int unsigned LANES = ddrcap_pkg::DEF_LANES,
  parameter int unsigned DEPTH = ddrcap_pkg::DEF_DEPTH
) (
  input  logic               cap_clk,
  input  logic               rd_clk,
  input  logic               rst_n,
  input  logic [LANES-1:0]   dq,
  input  logic               cap_en,
  input  logic               fifo_bypass,
  input  logic               rd_en,
  output logic [2*LANES-1:0] cap_pair,
  output logic               cap_vld,
  output logic               fifo_full,
  output logic [4*LANES-1:0] dout,
  output logic               dout_vld,
  output logic               fifo_empty
);
  localparam int unsigned PW = ddrcap_pkg::PAIR_BITS * LANES;
  localparam int unsigned WW = ddrcap_pkg::WORD_BITS * LANES;

  logic          cap_rst_n;
  logic          rd_rst_n;
  logic [PW-1:0] pair;
  logic          pair_vld;
  logic          wr_en;
  logic [WW-1:0] fifo_rdata;
  logic          fifo_rvld;

  ddrcap_rst_sync u_cap_rst (.clk(cap_clk), .arst_n(rst_n), .srst_n(cap_rst_n));
  ddrcap_rst_sync u_rd_rst  (.clk(rd_clk),  .arst_n(rst_n), .srst_n(rd_rst_n));

  ddrcap_front #(.LANES(LANES)) u_front (
    .cap_clk (cap_clk),
    .rst_n   (cap_rst_n),
    .dq      (dq),
    .cap_en  (cap_en),
    .pair    (pair),
    .pair_vld(pair_vld)
  );

  assign wr_en = pair_vld && !fifo_bypass;

  ddrcap_cdc_fifo #(.W(PW), .DEPTH(DEPTH)) u_fifo (
    .wclk  (cap_clk),
    .wrst_n(cap_rst_n),
    .wr_en (wr_en),
    .wdata (pair),
    .full  (fifo_full),
    .rclk  (rd_clk),
    .rrst_n(rd_rst_n),
    .rd_en (rd_en),
    .rdata (fifo_rdata),
    .rvld  (fifo_rvld),
    .empty (fifo_empty)
  );

  // regroup: per lane, older pair in low bits, newer pair above it
  for (genvar l = 0; l < LANES; l++) begin : g_word
    assign dout[4*l +: 4] = {fifo_rdata[PW + 2*l +: 2], fifo_rdata[2*l +: 2]};
  end

  assign cap_pair = pair;
  assign cap_vld  = pair_vld;
  assign dout_vld = fifo_rvld;

  // R8
  bypass_no_fill_chk: assert property (@(posedge cap_clk) disable iff (!cap_rst_n)
    (fifo_bypass && fifo_empty && $past(fifo_bypass)) |=> !fifo_full);
endmodule

// File: tb/ddr_rd_capture_tb.sv
`timescale 1ns/1ps
module ddr_rd_capture_tb;
  localparam int LANES = 2;

  logic             cap_clk = 1'b0;
  logic             rd_clk  = 1'b0;
  logic             rst_n;
  logic [LANES-1:0] dq;
  logic             cap_en;
  logic             fifo_bypass;
  logic             rd_en;
  logic [2*LANES-1:0] cap_pair;
  logic             cap_vld;
  logic             fifo_full;
  logic [4*LANES-1:0] dout;
  logic             dout_vld;
  logic             fifo_empty;

  always #5  cap_clk = ~cap_clk;   // capture clock, twice the read rate
  always #10 rd_clk  = ~rd_clk;    // 50 MHz system clock

  ddr_rd_capture #(.LANES(LANES), .DEPTH(8)) u_dut (
    .cap_clk(cap_clk), .rd_clk(rd_clk), .rst_n(rst_n), .dq(dq),
    .cap_en(cap_en), .fifo_bypass(fifo_bypass), .rd_en(rd_en),
    .cap_pair(cap_pair), .cap_vld(cap_vld), .fifo_full(fifo_full),
    .dout(dout), .dout_vld(dout_vld), .fifo_empty(fifo_empty)
  );

  // stimulus/expect table: bits [3:0] lane0 in arrival order, [7:4] lane1
  localparam logic [7:0] VEC [16] = '{
    8'h00, 8'hFF, 8'h5A, 8'hA5, 8'h01, 8'h80, 8'h3C, 8'hC3,
    8'h12, 8'h34, 8'h69, 8'h96, 8'hE7, 8'h18, 8'h0F, 8'hF0
  };

  int checks = 0;
  int fails  = 0;
  logic [7:0] rx  [64];
  int         rx_n = 0;
  logic [3:0] cp  [128];
  int         cp_n = 0;

  always @(negedge rd_clk) if (dout_vld && rx_n < 64) begin
    rx[rx_n] = dout; rx_n++;
  end
  always @(negedge cap_clk) if (cap_vld && cp_n < 128) begin
    cp[cp_n] = cap_pair; cp_n++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic drive_pair(input logic [1:0] rise_b, input logic [1:0] fall_b);
    @(negedge cap_clk); #2; dq = rise_b; cap_en = 1'b1;
    @(posedge cap_clk); #2; dq = fall_b;
  endtask

  task automatic idle();
    @(negedge cap_clk); #2; cap_en = 1'b0; dq = '0;
  endtask

  task automatic drive_word(input logic [7:0] v);
    for (int j = 0; j < 2; j++)
      drive_pair({v[4+2*j], v[2*j]}, {v[5+2*j], v[2*j+1]});
  endtask

  task automatic rd_wait(input int n);
    repeat (n) @(negedge rd_clk);
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_up();
  end

  initial begin
    int base;
    int cbase;
    rst_n = 1'b0; dq = '0; cap_en = 1'b0; fifo_bypass = 1'b0; rd_en = 1'b0;
    rd_wait(2);
    // R9 reset state
    chk(dout_vld == 1'b0,   "R9 reset dout_vld", dout_vld, 0);
    chk(fifo_empty == 1'b1, "R9 reset empty", fifo_empty, 1);
    chk(fifo_full == 1'b0,  "R9 reset full", fifo_full, 0);
    rst_n = 1'b1;
    rd_wait(6);
    rd_en = 1'b1;

    // R1 R3 R4 streaming table
    base = rx_n; cbase = cp_n;
    for (int i = 0; i < 16; i++) drive_word(VEC[i]);
    idle();
    rd_wait(20);
    chk(rx_n - base == 16, "R4 stream word count", rx_n - base, 16);
    for (int i = 0; i < 16; i++)
      chk(rx[base+i] == VEC[i], "R3 stream word", rx[base+i], VEC[i]);
    chk(cp[cbase+1] == {VEC[0][7:6], VEC[0][3:2]}, "R1 pair layout",
        cp[cbase+1], 0);
    chk(cp[cbase+5] == {VEC[2][7:6], VEC[2][3:2]}, "R1 pair layout",
        cp[cbase+5], {VEC[2][7:6], VEC[2][3:2]});
    chk(cp_n - cbase == 32, "R2 pair count", cp_n - cbase, 32);
    chk(fifo_empty == 1'b1, "R7 empty after stream", fifo_empty, 1);

    // R8 bypass: pairs visible, FIFO untouched
    @(negedge cap_clk); fifo_bypass = 1'b1;
    base = rx_n; cbase = cp_n;
    drive_word(VEC[2]); drive_word(VEC[9]);
    idle();
    rd_wait(12);
    chk(cp_n - cbase == 4, "R8 bypass pair count", cp_n - cbase, 4);
    chk(cp[cbase] == {VEC[2][5:4], VEC[2][1:0]}, "R8 bypass pair0",
        cp[cbase], {VEC[2][5:4], VEC[2][1:0]});
    chk(cp[cbase+3] == {VEC[9][7:6], VEC[9][3:2]}, "R8 bypass pair3",
        cp[cbase+3], {VEC[9][7:6], VEC[9][3:2]});
    chk(rx_n == base, "R8 bypass no word", rx_n - base, 0);
    chk(fifo_empty == 1'b1, "R8 bypass fifo empty", fifo_empty, 1);
    @(negedge cap_clk); fifo_bypass = 1'b0;

    // R6 fill with reads held off, R4 no words while rd_en low
    @(negedge rd_clk); rd_en = 1'b0;
    base = rx_n;
    for (int i = 0; i < 6; i++) drive_word(VEC[4+i]);
    idle();
    @(negedge cap_clk); @(negedge cap_clk);
    chk(fifo_full == 1'b1, "R6 full flag", fifo_full, 1);
    rd_wait(4);
    chk(rx_n == base, "R4 no read while rd_en low", rx_n - base, 0);
    @(negedge rd_clk); rd_en = 1'b1;
    rd_wait(20);
    chk(rx_n - base == 4, "R6 only depth kept", rx_n - base, 4);
    for (int i = 0; i < 4; i++)
      chk(rx[base+i] == VEC[4+i], "R6 kept word", rx[base+i], VEC[4+i]);
    @(negedge cap_clk);
    chk(fifo_full == 1'b0, "R6 full clears", fifo_full, 0);

    // R5 lone pair waits for its partner
    base = rx_n;
    drive_pair({VEC[6][4], VEC[6][0]}, {VEC[6][5], VEC[6][1]});
    idle();
    rd_wait(12);
    chk(rx_n == base, "R5 lone pair held", rx_n - base, 0);
    chk(fifo_empty == 1'b0, "R5 lone pair not empty", fifo_empty, 0);
    drive_pair({VEC[6][6], VEC[6][2]}, {VEC[6][7], VEC[6][3]});
    idle();
    rd_wait(12);
    chk(rx_n - base == 1, "R5 partner releases word", rx_n - base, 1);
    chk(rx[base] == VEC[6], "R5 joined word", rx[base], VEC[6]);

    // R9 reset with stored data, then fresh data
    @(negedge rd_clk); rd_en = 1'b0;
    for (int i = 0; i < 3; i++) drive_word(VEC[12+i]);
    idle();
    rd_wait(6);
    @(negedge rd_clk); rst_n = 1'b0; #1;
    chk(fifo_empty == 1'b1, "R9 mid reset empty", fifo_empty, 1);
    chk(dout_vld == 1'b0,   "R9 mid reset dout_vld", dout_vld, 0);
    chk(fifo_full == 1'b0,  "R9 mid reset full", fifo_full, 0);
    rd_wait(4);
    rst_n = 1'b1;
    rd_wait(6);
    rd_en = 1'b1;
    base = rx_n;
    for (int i = 0; i < 4; i++) drive_word(VEC[8+i]);
    idle();
    rd_wait(20);
    chk(rx_n - base == 4, "R9 words after reset", rx_n - base, 4);
    for (int i = 0; i < 4; i++)
      chk(rx[base+i] == VEC[8+i], "R9 word after reset", rx[base+i], VEC[8+i]);

    finish_up();
  end
endmodule